// File: doc/BRIEF.md
# Clock-Phase Alignment Wait Generator

This block sits between a bus controller's programmable cycle-pattern engine and a slave device clocked at an integer fraction (one half or one third) of the bus clock. The slow clock is phase-locked to the fast clock, and the block samples it to keep track of where each slow cycle begins. When the pattern engine drives its control line to the active level at the start of a pattern, the block raises its wait output and holds it until the next slow-cycle boundary. The pattern engine is thus stalled until its following steps line up with the slave's clock.

After the stall, the pattern engine returns its control line to idle. From then until the bus cycle ends, the same wait output carries the slave's acknowledge signal. At a 3:1 ratio the acknowledge passes through a two-flop synchronizer, so the pattern engine samples in the last third of the slow cycle. At a 2:1 ratio a build option can route the acknowledge straight through, so sampling lands in the second half of the slow cycle. A parameter sets whether the control line idles high (active low) or idles low (active high).

Top module: `phase_align_wait`

## Requirements
- R1: A synchronous active-high reset clears all state. While reset is sampled high, `waitOut` is 0 in the following cycle.
- R2: The block keeps a fast-clock phase count from 0 to RATIO-1. Phase 0 is the cycle that begins at the second rising `clk` edge after `slowClk` is first sampled high following a low sample. Phase 0 then recurs every RATIO cycles.
- R3: Suppose the control line is sampled active while the block is idle. `waitOut` is then 1 from the next cycle and stays 1 up to, but not including, the next phase-0 cycle, where it drops to 0. Each stall therefore lasts between 1 and RATIO cycles.
- R4: A stall whose first cycle falls on phase 0 lasts a full RATIO cycles; it ends at the following phase 0.
- R5: With CTRL_IDLE_HIGH=1 the control line is active when `ctrlIn`=0. With CTRL_IDLE_HIGH=0 it is active when `ctrlIn`=1.
- R6: After a stall ends, `waitOut` stays 0 while the control line is still active. In the cycle after the control line is first sampled inactive, `waitOut` begins to follow the acknowledge path.
- R7: In synchronized mode, `waitOut` during the transfer phase equals the `ackIn` value sampled two rising edges earlier.
- R8: In bypass mode (RATIO=2 and ACK_BYPASS=1), `waitOut` during the transfer phase equals `ackIn` combinationally. At RATIO=3, ACK_BYPASS has no effect and the synchronizer is used.
- R9: When idle, `waitOut` is 0 whatever the value of `ackIn`. During the transfer phase, changes on the control line have no effect.
- R10: `cycleEnd` sampled high during the transfer phase returns the block to idle. When sampled high at any other time it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slowClk | input | 1 | Slave clock, sampled as data in the fast domain |
| ctrlIn | input | 1 | Sync control line from the pattern engine |
| cycleEnd | input | 1 | One-cycle pulse that marks the end of the bus cycle |
| ackIn | input | 1 | Transfer acknowledge from the slave |
| waitOut | output | 1 | Wait/stall line to the pattern engine |

## Verification
The bench drives the control line active at every phase offset so that each stall length from 1 to RATIO occurs, including the full-length stall that starts on phase 0. A design that treated a phase-0 entry as already aligned would stall for zero cycles there, and an off-by-one phase tracker would end every stall one cycle away from the boundary. In the transfer phase the acknowledge is random, so a synchronizer with the wrong stage count, or one bypassed at the 3:1 ratio, shows up as a shifted wait pattern. Random `ackIn` and `cycleEnd` activity while idle or stalling, together with control-line toggles during the transfer phase, exposes a mux that leaks the acknowledge when idle or a state machine that reacts to inputs it should ignore.

// File: rtl/phase_wait_pkg.sv
package phase_wait_pkg;

  typedef enum logic [1:0] {
    SyncIdle,
    SyncStall,
    SyncHold,
    SyncXfer
  } syncState_e;

  // Strobes from the sync controller to the wait datapath
  typedef struct packed {
    logic selStall;   // force wait high
    logic selAck;     // route acknowledge path onto wait
  } waitStrobe_t;

endpackage

// File: rtl/pw_phase_track.sv
module pw_phase_track #(
  parameter int RATIO = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic slowClk,
  output logic phaseZero,
  output logic boundaryNext
);

  localparam int PH_W = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(RATIO - 1);

  logic            slowQ1;
  logic            slowQ2;
  logic [PH_W-1:0] phaseCnt;
  logic            riseSeen;

  assign riseSeen     = slowQ1 & ~slowQ2;
  assign boundaryNext = riseSeen | (phaseCnt == LAST_PH);
  assign phaseZero    = (phaseCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slowQ1   <= 1'b0;
      slowQ2   <= 1'b0;
      phaseCnt <= '0;
    end else begin
      slowQ1 <= slowClk;
      slowQ2 <= slowQ1;
      if (boundaryNext) phaseCnt <= '0;
      else              phaseCnt <= phaseCnt + 1'b1;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phaseCnt <= LAST_PH);  // R2

  AST_RISE_ALIGNS: assert property (@(posedge clk) disable iff (rst)
    riseSeen |=> phaseZero);  // R2

endmodule

// File: rtl/pw_sync_ctrl.sv
module pw_sync_ctrl
  import phase_wait_pkg::*;
#(
  parameter bit CTRL_IDLE_HIGH = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrlIn,
  input  logic        cycleEnd,
  input  logic        boundaryNext,
  output waitStrobe_t strb
);

  syncState_e state;
  syncState_e stateNext;
  logic       ctrlActive;

  generate
    if (CTRL_IDLE_HIGH) begin : g_active_low
      assign ctrlActive = ~ctrlIn;
    end else begin : g_active_high
      assign ctrlActive = ctrlIn;
    end
  endgenerate

  always_comb begin
    stateNext = state;
    unique case (state)
      SyncIdle:  if (ctrlActive)   stateNext = SyncStall;
      SyncStall: if (boundaryNext) stateNext = SyncHold;
      SyncHold:  if (!ctrlActive)  stateNext = SyncXfer;
      SyncXfer:  if (cycleEnd)     stateNext = SyncIdle;
      default:                     stateNext = SyncIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SyncIdle;
    else     state <= stateNext;
  end

  assign strb.selStall = (state == SyncStall);
  assign strb.selAck   = (state == SyncXfer);

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state == SyncIdle && ctrlActive) |=> strb.selStall);  // R3

  AST_XFER_STAYS: assert property (@(posedge clk) disable iff (rst)
    (strb.selAck && !cycleEnd) |=> strb.selAck);  // R9

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == SyncHold && ctrlActive) |=> !strb.selAck);  // R6

endmodule

// File: rtl/pw_wait_path.sv
module pw_wait_path
  import phase_wait_pkg::*;
#(
  parameter int RATIO      = 3,
  parameter bit ACK_BYPASS = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ackIn,
  input  waitStrobe_t strb,
  output logic        waitOut
);

  localparam int SYNC_STAGES = 2;
  localparam bit USE_BYPASS  = ACK_BYPASS && (RATIO == 2);

  logic ackPath;

  generate
    if (USE_BYPASS) begin : g_bypass
      assign ackPath = ackIn;

      AST_ACK_BYPASS: assert property (@(posedge clk) disable iff (rst)
        strb.selAck |-> (waitOut == ackIn));  // R8
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncPipe;

      always_ff @(posedge clk) begin
        if (rst) syncPipe <= '0;
        else     syncPipe <= {syncPipe[SYNC_STAGES-2:0], ackIn};
      end

      assign ackPath = syncPipe[SYNC_STAGES-1];

      AST_ACK_SYNC_LAT: assert property (@(posedge clk) disable iff (rst)
        strb.selAck |-> (waitOut == $past(ackIn, 2)));  // R7
    end
  endgenerate

  assign waitOut = strb.selStall | (strb.selAck & ackPath);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!strb.selStall && !strb.selAck) |-> !waitOut);  // R9

  AST_STALL_DRIVES: assert property (@(posedge clk) disable iff (rst)
    strb.selStall |-> waitOut);  // R3

endmodule

// File: rtl/phase_align_wait.sv
module phase_align_wait
  import phase_wait_pkg::*;
#(
  parameter int RATIO          = 3,
  parameter bit CTRL_IDLE_HIGH = 1'b1,
  parameter bit ACK_BYPASS     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic slowClk,
  input  logic ctrlIn,
  input  logic cycleEnd,
  input  logic ackIn,
  output logic waitOut
);

  logic        phaseZero;
  logic        boundaryNext;
  waitStrobe_t strb;

  pw_phase_track #(.RATIO(RATIO)) u_phase (
    .clk          (clk),
    .rst          (rst),
    .slowClk      (slowClk),
    .phaseZero    (phaseZero),
    .boundaryNext (boundaryNext)
  );

  pw_sync_ctrl #(.CTRL_IDLE_HIGH(CTRL_IDLE_HIGH)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .ctrlIn       (ctrlIn),
    .cycleEnd     (cycleEnd),
    .boundaryNext (boundaryNext),
    .strb         (strb)
  );

  pw_wait_path #(.RATIO(RATIO), .ACK_BYPASS(ACK_BYPASS)) u_path (
    .clk     (clk),
    .rst     (rst),
    .ackIn   (ackIn),
    .strb    (strb),
    .waitOut (waitOut)
  );

  AST_STALL_ENDS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ($past(strb.selStall) && !strb.selStall) |-> phaseZero);  // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !waitOut);  // R1

endmodule

// File: tb/test_phase_align_wait.sv
module pw_bench_unit #(
  parameter int RATIO     = 3,
  parameter bit IDLE_HIGH = 1'b1,
  parameter bit BYPASS    = 1'b0,
  parameter int NUM_TXN   = 150
) (
  input  logic clk,
  output int   compared,
  output int   mismatched,
  output logic done
);

  localparam bit BYP = BYPASS && (RATIO == 2);

  logic rst      = 1'b1;
  logic slowClk  = 1'b0;
  logic ctrlIn   = IDLE_HIGH;
  logic cycleEnd = 1'b0;
  logic ackIn    = 1'b0;
  logic waitOut;

  // reference model state (0 idle, 1 stall, 2 hold, 3 transfer)
  int    mSt = 0, mPh = 0, bSlot = 0;
  bit    mS1 = 0, mS2 = 0, mA1 = 0, mA2 = 0, fromZero = 0;
  bit    expW = 0;
  string tag = "R1";

  phase_align_wait #(
    .RATIO(RATIO), .CTRL_IDLE_HIGH(IDLE_HIGH), .ACK_BYPASS(BYPASS)
  ) i_phase_align_wait (
    .clk(clk), .rst(rst), .slowClk(slowClk), .ctrlIn(ctrlIn),
    .cycleEnd(cycleEnd), .ackIn(ackIn), .waitOut(waitOut)
  );

  function automatic string stateTag(input int st, input bit r, input bit fz);
    if (r)       return "R1";
    if (st == 1) return fz ? "R4/R5" : "R2/R3/R5";
    if (st == 2) return "R6";
    if (st == 3) return BYP ? "R8" : ((RATIO == 3) ? "R7/R8" : "R7");
    return "R9/R10";
  endfunction

  task automatic step(input bit r, input bit act, input bit ce, input bit ack);
    bit rise, nz;
    int nSt;
    @(negedge clk);
    compared++;
    if (waitOut !== expW) begin
      mismatched++;
      $display("FAIL %s: ratio %0d idleHigh %0b bypass %0b t=%0t waitOut=%0b expected %0b",
               tag, RATIO, IDLE_HIGH, BYPASS, $time, waitOut, expW);
    end
    rst      = r;
    slowClk  = (2 * bSlot < RATIO);
    ctrlIn   = IDLE_HIGH ? !act : act;
    cycleEnd = ce;
    ackIn    = ack;
    rise = mS1 && !mS2;
    nz   = rise || (mPh == RATIO - 1);
    nSt  = mSt;
    case (mSt)
      0: if (act) begin nSt = 1; fromZero = nz; end
      1: if (nz) nSt = 2;
      2: if (!act) nSt = 3;
      default: if (ce) nSt = 0;
    endcase
    mA2 = mA1;
    mA1 = ack;
    mS2 = mS1;
    mS1 = slowClk;
    mPh = nz ? 0 : mPh + 1;
    mSt = nSt;
    if (r) begin
      mSt = 0; mPh = 0; mS1 = 0; mS2 = 0; mA1 = 0; mA2 = 0;
    end
    bSlot = (bSlot + 1) % RATIO;
    if (mSt == 1)      expW = 1'b1;
    else if (mSt == 3) expW = BYP ? ack : mA2;
    else               expW = 1'b0;
    tag = stateTag(mSt, r, fromZero);
  endtask

  task automatic txn(input int gap, input int ctrlLen, input int xferLen);
    for (int i = 0; i < gap; i++) step(0, 0, $urandom % 3 == 0, $urandom % 2 == 1);
    for (int i = 0; i < ctrlLen; i++) step(0, 1, $urandom % 3 == 0, $urandom % 2 == 1);
    for (int i = 0; i < xferLen; i++) step(0, $urandom % 4 == 0, 0, $urandom % 2 == 1);
    step(0, 0, 1, $urandom % 2 == 1);
  endtask

  initial begin
    compared   = 0;
    mismatched = 0;
    done       = 1'b0;
    // reset with acknowledge toggling: R1
    for (int i = 0; i < 4; i++) step(1, 1, 1, i % 2 == 1);
    // idle with stray ack and cycleEnd: R9, R10
    for (int i = 0; i < 8; i++) step(0, 0, i % 3 == 0, i % 2 == 0);
    // directed sweep over every entry phase: R3, R4
    for (int off = 0; off < 3 * RATIO; off++) txn(off, RATIO + 1, 5);
    // control released as soon as possible: R6
    for (int off = 0; off < 2 * RATIO; off++) txn(off + 1, 1, 4);
    // constrained random traffic
    for (int n = 0; n < NUM_TXN; n++)
      txn($urandom % 5, 1 + $urandom % (2 * RATIO), 1 + $urandom % 8);
    // reset in the middle of a stall: R1
    txn(2, 0, 0);
    step(0, 1, 0, 1);
    step(1, 1, 0, 1);
    step(1, 1, 0, 1);
    for (int n = 0; n < 10; n++) txn($urandom % 4, 1 + $urandom % 4, 3);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    done = 1'b1;
  end

endmodule

module test_phase_align_wait;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int   cmp [4];
  int   mis [4];
  logic fin [4];

  pw_bench_unit #(.RATIO(2), .IDLE_HIGH(1'b1), .BYPASS(1'b0)) u_r2_low (
    .clk(clk), .compared(cmp[0]), .mismatched(mis[0]), .done(fin[0]));
  pw_bench_unit #(.RATIO(3), .IDLE_HIGH(1'b1), .BYPASS(1'b0)) u_r3_low (
    .clk(clk), .compared(cmp[1]), .mismatched(mis[1]), .done(fin[1]));
  pw_bench_unit #(.RATIO(2), .IDLE_HIGH(1'b0), .BYPASS(1'b1)) u_r2_byp (
    .clk(clk), .compared(cmp[2]), .mismatched(mis[2]), .done(fin[2]));
  pw_bench_unit #(.RATIO(3), .IDLE_HIGH(1'b0), .BYPASS(1'b1)) u_r3_byp (
    .clk(clk), .compared(cmp[3]), .mismatched(mis[3]), .done(fin[3]));

  initial begin
    int  totalCmp;
    int  totalMis;
    int  cycles;
    bit  allDone;
    void'($urandom(32'h5A17));
    cycles  = 0;
    allDone = 1'b0;
    while (!allDone && cycles < 150000) begin
      @(posedge clk);
      cycles++;
      allDone = fin[0] && fin[1] && fin[2] && fin[3];
    end
    @(negedge clk);
    totalCmp = 0;
    totalMis = 0;
    for (int k = 0; k < 4; k++) begin
      totalCmp += cmp[k];
      totalMis += mis[k];
    end
    if (!allDone) begin
      totalCmp++;
      totalMis++;
      $display("FAIL R1..: watchdog expired, actual still running expected all units done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", totalCmp, totalMis);
    $finish;
  end

endmodule